// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer channels of the kind found beside a small microcontroller core. Each channel keeps a low count byte and a high count byte. A four-bit configuration nibble per channel picks one of four modes, turns on gating by an external input and chooses between timer and counter function. In timer function a channel advances once per machine cycle, which is one pulse of an internal divider running from the block clock. In counter function it advances once for each falling edge seen on its count pin. Either way, a channel only counts while its run bit is set.

When a channel wraps it raises a sticky overflow flag, and software clears the flag by writing the control register. Channel 1 also drives a one-clock strobe on each wrap, which a serial baud generator can use. Split mode turns channel 0 into two free 8-bit counters. The upper counter takes over channel 1's flag, and channel 1 keeps counting in its own mode as a strobe source only.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads as zero. Reads return 0 for addresses 6 and 7. The register map is: address 0 holds the configuration, with channel 0 in bits 3:0 and channel 1 in bits 7:4, each nibble being {gate[3], counter[2], mode[1:0]}. Address 1 holds control, with run0 in bit 0, run1 in bit 1, flag0 in bit 4 and flag1 in bit 5. Addresses 2 and 3 are the low and high bytes of channel 0, and addresses 4 and 5 are the low and high bytes of channel 1.
- R2: A machine-cycle pulse occurs once every OSC_DIV clocks. In timer function an enabled channel advances by exactly one per pulse.
- R3: Mode 0 counts the 13-bit value {high, low[4:0]}. A carry out of bit 12 sets the flag and leaves both bytes at zero. Every increment writes low bits 7:5 back as zero.
- R4: Mode 1 counts {high, low} as one 16-bit value, and a carry out of bit 15 sets the flag.
- R5: In mode 2 only the low byte counts. When it wraps past 0xFF it is loaded from the high byte and the flag is set.
- R6: In mode 3 on channel 0, the low byte is an 8-bit counter under channel 0's full enable and sets flag0. The high byte is an 8-bit counter of machine cycles while run0 is set, and it sets flag1.
- R7: Channel 1 placed in mode 3 holds its count bytes.
- R8: A channel counts only while its run bit is set. When its gate bit is set it also needs its gate input to be high.
- R9: In counter function a channel advances once for each 1-to-0 transition of its count pin. The pin passes through two synchroniser flops and is compared between successive machine-cycle samples.
- R10: Flags stay set until a control write loads them from data bits 5:4. In the same clock, a write to a count byte wins over an increment of that channel, and a control write wins over a flag being set.
- R11: Each channel 1 wrap produces a one-clock pulse on baud_ovf_o. While channel 0 is in mode 3 that wrap does not set flag1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (oscillator) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | BYTE_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | BYTE_W | Combinational read data |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| gate_i | input | 2 | Gate inputs, one per channel, active high |
| ovf_flag_o | output | 2 | Sticky overflow flags |
| baud_ovf_o | output | 1 | One-clock strobe on channel 1 wrap |

## Verification
On every cycle the in-line assertions check several properties. The machine-cycle pulse never lasts two clocks. A channel with no increment and no write keeps its bytes. Channel 1 in mode 3 never moves. Flags do not drop without a control write. The baud strobe is a single clock wide, and a channel 1 wrap during split mode does not raise flag1. Only the bench's scenarios can show the exact values each mode produces: the 13-bit packing and its cleared upper bits, the reload value, the split counters' wraps, write-over-increment priority and edge counting on the pins. These are compared against a behavioural model on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      TM_13     = 2'd0,
      TM_16     = 2'd1,
      TM_RELOAD = 2'd2,
      TM_SPLIT  = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic      gate;
      logic      ext_cnt;
      tmr_mode_e mode;
   } tmr_cfg_t;

   localparam int unsigned A_CFG  = 0;
   localparam int unsigned A_CTRL = 1;
   localparam int unsigned A_LO0  = 2;
   localparam int unsigned A_HI0  = 3;
   localparam int unsigned A_LO1  = 4;
   localparam int unsigned A_HI1  = 5;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned DIV = 12
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic mc_o
);
   localparam int unsigned DW = (DIV < 2) ? 1 : $clog2(DIV);
   localparam logic [DW-1:0] LAST = DW'(DIV - 1);
   localparam logic [DW-1:0] ONE  = DW'(1);

   if (DIV < 2) begin : g_bad_div
      $error("tmr_prescale: DIV must be at least 2");
   end

   logic [DW-1:0] div_q;

   assign mc_o = (div_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   div_q <= '0;
      else if (mc_o) div_q <= '0;
      else           div_q <= div_q + ONE;
   end

   // R2: machine-cycle pulse is never two clocks wide
   a_r2_mc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mc_o |=> !mc_o);

endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
   parameter int unsigned N = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] pin_i,
   input  logic         mc_i,
   output logic [N-1:0] fall_o
);
   if (N < 1) begin : g_bad_n
      $error("tmr_edge_det: N must be at least 1");
   end

   logic [N-1:0] s1_q, s2_q, prv_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s1_q  <= '0;
         s2_q  <= '0;
         prv_q <= '0;
      end else begin
         s1_q <= pin_i;
         s2_q <= s1_q;
         if (mc_i) prv_q <= s2_q;
      end
   end

   assign fall_o = prv_q & ~s2_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
   parameter int unsigned BW       = 8,
   parameter int unsigned LOW13    = 5,
   parameter bit          SPLIT_OK = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  tmr_mode_e     mode_i,
   input  logic          inc_i,
   input  logic          inc_hi_i,
   input  logic          wr_lo_i,
   input  logic          wr_hi_i,
   input  logic [BW-1:0] wr_data_i,
   output logic [BW-1:0] lo_o,
   output logic [BW-1:0] hi_o,
   output logic          ovf_o,
   output logic          ovf_hi_o
);
   localparam int unsigned W13 = BW + LOW13;
   localparam int unsigned W16 = 2 * BW;
   localparam logic [W13:0] ONE13 = (W13 + 1)'(1);
   localparam logic [W16:0] ONE16 = (W16 + 1)'(1);
   localparam logic [BW:0]  ONE8  = (BW + 1)'(1);

   if (LOW13 >= BW) begin : g_bad_low
      $error("tmr_channel: LOW13 must be narrower than BW");
   end

   logic [BW-1:0] lo_q, hi_q, lo_n, hi_n;
   logic [W13:0]  sum13;
   logic [W16:0]  sum16;
   logic [BW:0]   sum_lo, sum_hi;
   logic          hold;

   assign sum13  = {1'b0, hi_q, lo_q[LOW13-1:0]} + ONE13;
   assign sum16  = {1'b0, hi_q, lo_q} + ONE16;
   assign sum_lo = {1'b0, lo_q} + ONE8;
   assign sum_hi = {1'b0, hi_q} + ONE8;
   assign hold   = wr_lo_i | wr_hi_i;

   always_comb begin
      lo_n     = lo_q;
      hi_n     = hi_q;
      ovf_o    = 1'b0;
      ovf_hi_o = 1'b0;
      if (!hold) begin
         unique case (mode_i)
            TM_13: if (inc_i) begin
               ovf_o = sum13[W13];
               hi_n  = sum13[W13-1:LOW13];
               lo_n  = {{(BW-LOW13){1'b0}}, sum13[LOW13-1:0]};
            end
            TM_16: if (inc_i) begin
               {ovf_o, hi_n, lo_n} = sum16;
            end
            TM_RELOAD: if (inc_i) begin
               if (sum_lo[BW]) begin
                  lo_n  = hi_q;
                  ovf_o = 1'b1;
               end else begin
                  lo_n = sum_lo[BW-1:0];
               end
            end
            TM_SPLIT: if (SPLIT_OK) begin
               if (inc_i)    {ovf_o, lo_n} = sum_lo;
               if (inc_hi_i) {ovf_hi_o, hi_n} = sum_hi;
            end
            default: ;
         endcase
      end
      if (wr_lo_i) lo_n = wr_data_i;
      if (wr_hi_i) hi_n = wr_data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   assign lo_o = lo_q;
   assign hi_o = hi_q;

   // R8: without an increment or write, the count bytes do not move
   a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !inc_hi_i && !hold) |=> $stable({hi_q, lo_q}));

   if (!SPLIT_OK) begin : g_nosplit_chk
      // R7: a channel without split support freezes in mode 3
      a_r7_split_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (mode_i == TM_SPLIT && !hold) |=> $stable({hi_q, lo_q}));
   end

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pkg::*; #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned LOW13_W = 5,
   parameter int unsigned OSC_DIV = 12,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [BYTE_W-1:0] rd_data_o,
   input  logic [1:0]        cnt_pin_i,
   input  logic [1:0]        gate_i,
   output logic [1:0]        ovf_flag_o,
   output logic              baud_ovf_o
);
   localparam int unsigned NCH   = 2;
   localparam int unsigned CFG_W = $bits(tmr_cfg_t);

   if (BYTE_W < 8) begin : g_bad_byte
      $error("tmr_pair: BYTE_W must be at least 8");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("tmr_pair: ADDR_W must be at least 3");
   end

   logic                 mc;
   logic [NCH-1:0]       fall;
   logic [7:0]           cfg_q;
   logic [NCH-1:0]       run_q, flag_q;
   logic                 baud_q;
   logic                 wr_cfg, wr_ctrl;
   logic [NCH-1:0]       wr_lo, wr_hi, en, ovf, ovf_hi;
   logic [BYTE_W-1:0]    lo_v [NCH];
   logic [BYTE_W-1:0]    hi_v [NCH];
   tmr_cfg_t             cfg [NCH];
   logic                 split0, set1;

   tmr_prescale #(.DIV(OSC_DIV)) u_pre (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mc_o  (mc)
   );

   tmr_edge_det #(.N(NCH)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (cnt_pin_i),
      .mc_i  (mc),
      .fall_o(fall)
   );

   assign wr_cfg  = wr_en_i && (wr_addr_i == ADDR_W'(A_CFG));
   assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int unsigned LO_A = (c == 0) ? A_LO0 : A_LO1;
      localparam int unsigned HI_A = (c == 0) ? A_HI0 : A_HI1;

      assign cfg[c]   = tmr_cfg_t'(cfg_q[CFG_W*c +: CFG_W]);
      assign wr_lo[c] = wr_en_i && (wr_addr_i == ADDR_W'(LO_A));
      assign wr_hi[c] = wr_en_i && (wr_addr_i == ADDR_W'(HI_A));
      assign en[c]    = mc && run_q[c] && (!cfg[c].gate || gate_i[c]) &&
                        (cfg[c].ext_cnt ? fall[c] : 1'b1);

      tmr_channel #(
         .BW      (BYTE_W),
         .LOW13   (LOW13_W),
         .SPLIT_OK(c == 0)
      ) u_chan (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .mode_i   (cfg[c].mode),
         .inc_i    (en[c]),
         .inc_hi_i ((c == 0) ? (mc && run_q[0]) : 1'b0),
         .wr_lo_i  (wr_lo[c]),
         .wr_hi_i  (wr_hi[c]),
         .wr_data_i(wr_data_i),
         .lo_o     (lo_v[c]),
         .hi_o     (hi_v[c]),
         .ovf_o    (ovf[c]),
         .ovf_hi_o (ovf_hi[c])
      );
   end

   assign split0 = (cfg[0].mode == TM_SPLIT);
   assign set1   = split0 ? (|ovf_hi) : ovf[1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q  <= '0;
         run_q  <= '0;
         flag_q <= '0;
         baud_q <= 1'b0;
      end else begin
         baud_q <= ovf[1];
         if (wr_cfg) cfg_q <= wr_data_i[7:0];
         if (wr_ctrl) begin
            run_q  <= wr_data_i[1:0];
            flag_q <= wr_data_i[5:4];
         end else begin
            flag_q <= flag_q | {set1, ovf[0]};
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         ADDR_W'(A_CFG):  rd_data_o = BYTE_W'(cfg_q);
         ADDR_W'(A_CTRL): rd_data_o = BYTE_W'({2'b00, flag_q, 2'b00, run_q});
         ADDR_W'(A_LO0):  rd_data_o = lo_v[0];
         ADDR_W'(A_HI0):  rd_data_o = hi_v[0];
         ADDR_W'(A_LO1):  rd_data_o = lo_v[1];
         ADDR_W'(A_HI1):  rd_data_o = hi_v[1];
         default:         rd_data_o = '0;
      endcase
   end

   assign ovf_flag_o = flag_q;
   assign baud_ovf_o = baud_q;

   for (genvar c = 0; c < NCH; c++) begin : g_flag_chk
      // R10: a flag only drops through a control write
      a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flag_q[c] && !wr_ctrl) |=> flag_q[c]);
   end

   // R11: the baud strobe lasts one clock
   a_r11_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      baud_q |=> !baud_q);

   // R11: in split mode a channel 1 wrap leaves flag1 alone
   a_r11_split_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (split0 && ovf[1] && !ovf_hi[0] && !wr_ctrl && !flag_q[1]) |=> !flag_q[1]);

endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
   localparam int DIV = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [1:0] cnt_pin = '0;
   logic [1:0] gate_in = '0;
   logic [1:0] flags;
   logic       baud;

   int  n_chk = 0;
   int  n_fail = 0;
   int  n_baud = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   tmr_pair u_tmr_pair (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .cnt_pin_i (cnt_pin),
      .gate_i    (gate_in),
      .ovf_flag_o(flags),
      .baud_ovf_o(baud)
   );

   // behavioural reference model
   int   m_div;
   int   m_cfg;
   int   m_lo [2];
   int   m_hi [2];
   bit   m_run [2];
   bit   m_flag [2];
   bit   m_baud;
   bit   m_s1 [2];
   bit   m_s2 [2];
   bit   m_prv [2];

   function automatic void chan_step(input int md, input bit en, input bit en_hi,
                                     input bit can_split, inout int lo, inout int hi,
                                     output bit ov, output bit ov_hi);
      int v;
      ov = 1'b0;
      ov_hi = 1'b0;
      case (md)
         0: if (en) begin
            v = hi * 32 + (lo % 32) + 1;
            if (v >= 8192) begin ov = 1'b1; v = v - 8192; end
            hi = v / 32;
            lo = v % 32;
         end
         1: if (en) begin
            v = hi * 256 + lo + 1;
            if (v >= 65536) begin ov = 1'b1; v = v - 65536; end
            hi = v / 256;
            lo = v % 256;
         end
         2: if (en) begin
            if (lo == 255) begin lo = hi; ov = 1'b1; end
            else lo = lo + 1;
         end
         default: if (can_split) begin
            if (en) begin
               lo = lo + 1;
               if (lo == 256) begin lo = 0; ov = 1'b1; end
            end
            if (en_hi) begin
               hi = hi + 1;
               if (hi == 256) begin hi = 0; ov_hi = 1'b1; end
            end
         end
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_div = 0; m_cfg = 0; m_baud = 0;
         for (int c = 0; c < 2; c++) begin
            m_lo[c] = 0; m_hi[c] = 0; m_run[c] = 0; m_flag[c] = 0;
            m_s1[c] = 0; m_s2[c] = 0; m_prv[c] = 0;
         end
      end else begin
         bit mcy, ov0, ovh, ov1, unused_hi;
         bit en [2];
         int nib, a;
         mcy = (m_div == DIV - 1);
         for (int c = 0; c < 2; c++) begin
            nib = (m_cfg >> (4 * c)) & 15;
            en[c] = mcy && m_run[c] && (((nib & 8) == 0) || gate_in[c]) &&
                    (((nib & 4) != 0) ? (m_prv[c] && !m_s2[c]) : 1'b1);
         end
         a = wr_en ? int'(wr_addr) : -1;
         ov0 = 0; ovh = 0; ov1 = 0; unused_hi = 0;
         if (a != 2 && a != 3)
            chan_step(m_cfg & 3, en[0], mcy && m_run[0], 1'b1, m_lo[0], m_hi[0], ov0, ovh);
         if (a != 4 && a != 5)
            chan_step((m_cfg >> 4) & 3, en[1], 1'b0, 1'b0, m_lo[1], m_hi[1], ov1, unused_hi);
         if (a == 2) m_lo[0] = int'(wr_data);
         if (a == 3) m_hi[0] = int'(wr_data);
         if (a == 4) m_lo[1] = int'(wr_data);
         if (a == 5) m_hi[1] = int'(wr_data);
         if (a == 1) begin
            m_run[0] = wr_data[0]; m_run[1] = wr_data[1];
            m_flag[0] = wr_data[4]; m_flag[1] = wr_data[5];
         end else begin
            if (ov0) m_flag[0] = 1;
            if (((m_cfg & 3) == 3) ? ovh : ov1) m_flag[1] = 1;
         end
         m_baud = ov1;
         if (a == 0) m_cfg = int'(wr_data);
         for (int c = 0; c < 2; c++) begin
            if (mcy) m_prv[c] = m_s2[c];
            m_s2[c] = m_s1[c];
            m_s1[c] = cnt_pin[c];
         end
         m_div = mcy ? 0 : m_div + 1;
      end
   end

   function automatic int mread(input int a);
      case (a)
         0: return m_cfg;
         1: return (int'(m_flag[1]) << 5) | (int'(m_flag[0]) << 4) |
                   (int'(m_run[1]) << 1) | int'(m_run[0]);
         2: return m_lo[0];
         3: return m_hi[0];
         4: return m_lo[1];
         5: return m_hi[1];
         default: return 0;
      endcase
   endfunction

   task automatic check(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #1;
         check(int'(flags), (int'(m_flag[1]) << 1) | int'(m_flag[0]), "R10 flags vs model");
         check(int'(baud), int'(m_baud), "R11 strobe vs model");
         check(int'(rd_data), mread(int'(rd_addr)), "R1 read vs model");
      end
   end

   always @(negedge clk) if (baud) n_baud++;

   task automatic w(input int a, input int d);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input int a, input int exp, input string tag);
      @(negedge clk);
      rd_addr = 3'(a);
      #2;
      check(int'(rd_data), exp, tag);
   endtask

   task automatic flag_chk(input int exp, input string tag);
      #1;
      check(int'(flags), exp, tag);
   endtask

   // start counting at a known prescaler phase; returns after exactly k machine cycles
   task automatic run_for(input int ctrl, input int k);
      while (m_div != 0) @(negedge clk);
      w(1, ctrl);
      repeat (DIV * k - 1) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 7; a++) rd_chk(a, 0, "R1 reset value");

      w(0, 8'hA5); w(1, 8'h33);
      rd_chk(0, 8'hA5, "R1 config readback");
      rd_chk(1, 8'h33, "R1 control readback");
      @(negedge clk); w(1, 0);
      rd_chk(1, 0, "R10 control write clears flags");

      // R2 / R4
      @(negedge clk); w(0, 8'h01); w(2, 0); w(3, 0);
      run_for(1, 5); flag_chk(0, "R2 no flag"); w(1, 0);
      rd_chk(2, 5, "R2 one step per machine cycle");
      rd_chk(3, 0, "R2 high byte");
      @(negedge clk); w(2, 8'hFF); w(3, 8'h12);
      run_for(1, 1); w(1, 0);
      rd_chk(2, 0, "R4 low carry"); rd_chk(3, 8'h13, "R4 high carry");
      @(negedge clk); w(2, 8'hFE); w(3, 8'hFF);
      run_for(1, 3); flag_chk(1, "R4 wrap flag"); w(1, 0);
      rd_chk(2, 1, "R4 low after wrap"); rd_chk(3, 0, "R4 high after wrap");

      // R3
      @(negedge clk); w(0, 8'h00); w(2, 8'hFE); w(3, 8'hFF);
      run_for(1, 2); flag_chk(1, "R3 13-bit wrap flag"); w(1, 0);
      rd_chk(2, 0, "R3 low after wrap"); rd_chk(3, 0, "R3 high after wrap");
      @(negedge clk); w(2, 8'hFF); w(3, 8'h40);
      run_for(1, 1); flag_chk(0, "R3 no flag"); w(1, 0);
      rd_chk(2, 0, "R3 five-bit carry"); rd_chk(3, 8'h41, "R3 high step");
      @(negedge clk); w(2, 8'hE3); w(3, 0);
      run_for(1, 1); w(1, 0);
      rd_chk(2, 8'h04, "R3 upper low bits cleared");

      // R5
      @(negedge clk); w(0, 8'h02); w(3, 8'hF0); w(2, 8'hFE);
      run_for(1, 3); flag_chk(1, "R5 reload flag"); w(1, 0);
      rd_chk(2, 8'hF1, "R5 reloaded low"); rd_chk(3, 8'hF0, "R5 reload value kept");

      // R8
      @(negedge clk); w(0, 8'h09); w(2, 0); w(3, 0); gate_in = 2'b00;
      run_for(1, 3); w(1, 0);
      rd_chk(2, 0, "R8 gate low blocks");
      @(negedge clk); gate_in = 2'b01;
      run_for(1, 3); w(1, 0);
      rd_chk(2, 3, "R8 gate high counts");
      @(negedge clk); gate_in = 2'b00; w(0, 8'h01);
      repeat (40) @(negedge clk);
      rd_chk(2, 3, "R8 run clear blocks");

      // R6
      @(negedge clk); w(0, 8'h03); w(2, 8'hFE); w(3, 8'hFD);
      run_for(1, 3); flag_chk(3, "R6 both split flags"); w(1, 0);
      rd_chk(2, 1, "R6 split low"); rd_chk(3, 0, "R6 split high");

      // R11 split: channel 1 wrap pulses strobe only
      @(negedge clk); w(0, 8'h13); w(2, 0); w(3, 8'h10); w(4, 8'hFF); w(5, 8'hFF);
      b0 = n_baud;
      run_for(3, 1); flag_chk(0, "R11 split wrap leaves flag1"); w(1, 0);
      check(n_baud - b0, 1, "R11 strobe count in split");
      rd_chk(4, 0, "R11 channel 1 low wrapped"); rd_chk(3, 8'h11, "R6 split high steps on run0");

      // R11 normal
      @(negedge clk); w(0, 8'h11); w(4, 8'hFF); w(5, 8'hFF);
      b0 = n_baud;
      run_for(2, 1); flag_chk(2, "R11 normal wrap sets flag1"); w(1, 0);
      check(n_baud - b0, 1, "R11 strobe count normal");

      // R7
      @(negedge clk); w(0, 8'h30); w(4, 8'h33); w(5, 8'h44);
      run_for(2, 4); flag_chk(0, "R7 no flag"); w(1, 0);
      rd_chk(4, 8'h33, "R7 low held"); rd_chk(5, 8'h44, "R7 high held");

      // R9
      @(negedge clk); w(0, 8'h50); w(4, 0); w(5, 0); w(1, 2);
      for (int p = 0; p < 3; p++) begin
         cnt_pin[1] = 1'b1; repeat (40) @(negedge clk);
         cnt_pin[1] = 1'b0; repeat (40) @(negedge clk);
      end
      w(1, 0);
      rd_chk(4, 3, "R9 falling edges counted"); rd_chk(5, 0, "R9 high byte");

      // R10 write priority and stickiness
      @(negedge clk); w(0, 8'h01); w(2, 8'h20); w(3, 0);
      while (m_div != 0) @(negedge clk);
      w(1, 1);
      repeat (10) @(negedge clk);
      w(2, 8'h55);
      w(1, 0);
      rd_chk(2, 8'h55, "R10 write beats increment");
      @(negedge clk); w(1, 8'h10);
      repeat (30) @(negedge clk);
      flag_chk(1, "R10 flag sticky");
      @(negedge clk); w(1, 0);
      flag_chk(0, "R10 flag cleared");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule